// File: doc/BRIEF.md
# Sectioned GPIO Controller with Pin Interrupts

This block is a memory-mapped controller for 32 general-purpose pins, arranged as four banks of eight. Every bank has its own register window. The window sets each pin's direction and output value, reports the input value after synchronization, and manages the pin interrupts: pending flags, masks, and the choice between edge and level triggering. Software reaches these windows over a small synchronous register port. A read returns its data together with an acknowledge one clock after the request.

A pin is numbered n. It lives in bank n>>3 at bit n&7, and bank b's window starts at byte b*0x40. Input pins go through a two-flop synchronizer before any logic sees them. A rising edge of the synchronized value, or a high level, records a pending flag. One interrupt output combines the unmasked pending flags of all four banks.

Top module: `gpio_sect_ctrl`

## Requirements
- R1: After reset, every bank has direction 0xFF (all pins inputs), output data 0x00, mask 0xFF, pending 0x00 and type 0x00 (all pins edge-triggered), so pin_oe_o and pin_o are all zero and irq_o is low.
- R2: Address bits [7:6] select the bank, and bits [5:0] select the register inside it. Pin n maps to bit n&7 of bank n>>3, for example pin 10 is bit 2 of the bank at 0x40.
- R3: The direction register at bank offset 0x10 holds 1 for an input and 0 for an output, and pin_oe_o is its inverse. The output register at offset 0x14 drives pin_o directly. Both read back what was written.
- R4: Offset 0x18 is read-only and returns the pin inputs after a two-flop synchronizer, so a pin change can be read two clocks after it arrives.
- R5: For an edge-triggered pin, a rising edge of the synchronized input sets its pending flag in the third clock after the pin changes. A pin that stays high does not set the flag again once it has been cleared.
- R6: For a level-triggered pin, the pending flag is set on every clock while the synchronized input is high, so a clear issued while the pin is high has no lasting effect.
- R7: Offset 0x04 reads the raw pending flags. Writing it clears each flag whose bit is 1 and leaves the flags written as 0 unchanged.
- R8: Writing offset 0x08 sets the mask bits written as 1, and reading it returns the mask. Writing offset 0x0C clears the mask bits written as 1. Offset 0x0C reads as 0.
- R9: Offset 0x00 is read-only and returns pending AND NOT mask. Writes to it change nothing.
- R10: irq_o is the OR of the masked pending flags of all four banks. Writing 0xFF to the mask address of every bank forces it low.
- R11: Writing offset 0x20 marks each pin whose bit is 1 as level-triggered, and reading it returns the type bits (1 = level).
- R12: A read request (req_i high, we_i low) raises ack_o in the next clock, with rdata_o holding the addressed register in bits [7:0] and zeros above. Unmapped offsets read as 0, and writes produce no ack_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address: bank in [7:6], offset in [5:0] |
| wdata_i | input | 32 | Write data (bits [7:0] used) |
| rdata_o | output | 32 | Read data, valid with ack_o |
| ack_o | output | 1 | Read response, one clock after the request |
| pin_i | input | 32 | Pin input levels, asynchronous |
| pin_o | output | 32 | Pin output values |
| pin_oe_o | output | 32 | Pin output enables (1 = driven) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is a clear racing against a source that is still active. The bench holds a level-typed pin high and then writes a clear. It also clears an edge-typed pin while its input stays high. After each clear it reads the pending flags again. The first flag must come back and the second must stay clear. A further case has events pending in more than one bank while all four masks are set to full, and irq_o must drop at once. The bench drives the raw pins from a negative edge and waits the three clocks through the synchronizer. Its checks therefore land on the cycle where the flag first becomes visible.

// File: rtl/gpio_sect_pkg.sv
package gpio_sect_pkg;
  localparam int unsigned NUM_SECT = 4;
  localparam int unsigned SECT_W   = 8;
  localparam int unsigned OFF_W    = 6;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned SEL_W    = $clog2(NUM_SECT);
  localparam int unsigned ADDR_W   = SEL_W + OFF_W;
  localparam int unsigned NUM_PINS = NUM_SECT * SECT_W;

  localparam logic [OFF_W-1:0] OFF_MSTAT = 6'h00;
  localparam logic [OFF_W-1:0] OFF_STAT  = 6'h04;
  localparam logic [OFF_W-1:0] OFF_MSET  = 6'h08;
  localparam logic [OFF_W-1:0] OFF_MCLR  = 6'h0C;
  localparam logic [OFF_W-1:0] OFF_DIR   = 6'h10;
  localparam logic [OFF_W-1:0] OFF_OUT   = 6'h14;
  localparam logic [OFF_W-1:0] OFF_IN    = 6'h18;
  localparam logic [OFF_W-1:0] OFF_TYPE  = 6'h20;
endpackage

// File: rtl/gpio_sect_sync.sv
module gpio_sect_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_sect_evt.sv
module gpio_sect_evt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] level_mode_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] prev_q, pend_q, set_w;

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign set_w[b] = level_mode_i[b] ? lvl_i[b] : (lvl_i[b] & ~prev_q[b]);
  end

  // a new event wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= lvl_i;
      pend_q <= (pend_q & ~clr_i) | set_w;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/gpio_sect_bank.sv
module gpio_sect_bank
  import gpio_sect_pkg::*;
#(
  parameter int unsigned W = SECT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [W-1:0]     pin_i,
  output logic [W-1:0]     rdata_o,
  output logic [W-1:0]     out_o,
  output logic [W-1:0]     oe_o,
  output logic             irq_o
);
  logic [W-1:0] dir_q, out_q, mask_q, type_q;
  logic [W-1:0] sync_w, pend_w, clr_w;

  gpio_sect_sync #(.W(W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync_w)
  );

  assign clr_w = (wr_i && off_i == OFF_STAT) ? wdata_i : '0;

  gpio_sect_evt #(.W(W)) u_evt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lvl_i       (sync_w),
    .level_mode_i(type_q),
    .clr_i       (clr_w),
    .pend_o      (pend_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '1;
      out_q  <= '0;
      mask_q <= '1;
      type_q <= '0;
    end else if (wr_i) begin
      unique case (off_i)
        OFF_MSET: mask_q <= mask_q | wdata_i;
        OFF_MCLR: mask_q <= mask_q & ~wdata_i;
        OFF_DIR:  dir_q  <= wdata_i;
        OFF_OUT:  out_q  <= wdata_i;
        OFF_TYPE: type_q <= type_q | wdata_i;
        default:  ;
      endcase
    end
  end

  always_comb begin
    unique case (off_i)
      OFF_MSTAT: rdata_o = pend_w & ~mask_q;
      OFF_STAT:  rdata_o = pend_w;
      OFF_MSET:  rdata_o = mask_q;
      OFF_DIR:   rdata_o = dir_q;
      OFF_OUT:   rdata_o = out_q;
      OFF_IN:    rdata_o = sync_w;
      OFF_TYPE:  rdata_o = type_q;
      default:   rdata_o = '0;
    endcase
  end

  assign out_o = out_q;
  assign oe_o  = ~dir_q;
  assign irq_o = |(pend_w & ~mask_q);
endmodule

// File: rtl/gpio_sect_ctrl.sv
module gpio_sect_ctrl
  import gpio_sect_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                ack_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic                irq_o
);
  logic [SEL_W-1:0]  sel_w;
  logic [OFF_W-1:0]  off_w;
  logic [SECT_W-1:0] bank_rd [NUM_SECT];
  logic [NUM_SECT-1:0] bank_irq;
  logic [DATA_W-1:0] rdata_q;
  logic              ack_q;

  assign sel_w = addr_i[ADDR_W-1:OFF_W];
  assign off_w = addr_i[OFF_W-1:0];

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_bank
    logic wr_w;
    assign wr_w = req_i && we_i && (sel_w == SEL_W'(s));

    gpio_sect_bank #(.W(SECT_W)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (wr_w),
      .off_i  (off_w),
      .wdata_i(wdata_i[SECT_W-1:0]),
      .pin_i  (pin_i[s*SECT_W +: SECT_W]),
      .rdata_o(bank_rd[s]),
      .out_o  (pin_o[s*SECT_W +: SECT_W]),
      .oe_o   (pin_oe_o[s*SECT_W +: SECT_W]),
      .irq_o  (bank_irq[s])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      ack_q   <= 1'b0;
    end else begin
      ack_q <= req_i && !we_i;
      if (req_i && !we_i) rdata_q <= {{(DATA_W-SECT_W){1'b0}}, bank_rd[sel_w]};
    end
  end

  assign rdata_o = rdata_q;
  assign ack_o   = ack_q;
  assign irq_o   = |bank_irq;
endmodule

// File: rtl/gpio_sect_chk.sv
module gpio_sect_chk
  import gpio_sect_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic [DATA_W-1:0]   rdata_o,
  input logic                ack_o,
  input logic [NUM_PINS-1:0] pin_o,
  input logic [NUM_PINS-1:0] pin_oe_o,
  input logic                irq_o
);
  logic first_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) first_q <= 1'b1;
    else         first_q <= 1'b0;
  end

  // R1
  rst_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_q |-> (pin_o == '0 && pin_oe_o == '0 && !irq_o));

  // R12
  rd_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> ack_o);

  // R12
  no_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !ack_o);

  // R12
  rd_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> rdata_o[DATA_W-1:SECT_W] == '0);

  // R3
  dir_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == {2'd0, OFF_DIR}) |=> pin_oe_o[SECT_W-1:0] == ~$past(wdata_i[SECT_W-1:0]));

  // R3
  out_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == {2'd1, OFF_OUT}) |=> pin_o[2*SECT_W-1:SECT_W] == $past(wdata_i[SECT_W-1:0]));
endmodule

bind gpio_sect_ctrl gpio_sect_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .ack_o   (ack_o),
  .pin_o   (pin_o),
  .pin_oe_o(pin_oe_o),
  .irq_o   (irq_o)
);

// File: tb/tb_gpio_sect_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_sect_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        ack_o;
  logic [31:0] pin_i = '0;
  logic [31:0] pin_o, pin_oe_o;
  logic        irq_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #2 clk = ~clk;

  gpio_sect_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ack_o(ack_o), .pin_i(pin_i),
    .pin_o(pin_o), .pin_oe_o(pin_oe_o), .irq_o(irq_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req_i = 1'b0;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (ack_o) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R12: unexpected ack, actual %h expected none", rdata_o);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, rdata_o, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    settle(3);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pin_oe", pin_oe_o, 32'h0);
    check("R1 pin_o", pin_o, 32'h0);
    check("R1 irq", {31'h0, irq_o}, 32'h0);
    for (int s = 0; s < 4; s++) begin
      rd(8'(s*64) + 8'h10, 32'hFF, "R1 dir");
      rd(8'(s*64) + 8'h08, 32'hFF, "R1 mask");
      rd(8'(s*64) + 8'h04, 32'h00, "R1 pend");
      rd(8'(s*64) + 8'h20, 32'h00, "R1 type");
      rd(8'(s*64) + 8'h14, 32'h00, "R1 out");
    end
    // R12 unmapped and write-only offsets read zero
    rd(8'h0C, 32'h0, "R12/R8 mclr reads zero");
    rd(8'h24, 32'h0, "R12 unmapped");
    rd(8'hFC, 32'h0, "R12 unmapped top");

    // R3 / R2 direction and output in bank 1
    wr(8'h50, 32'hFFFF_FFF0);
    check("R3 oe bank1", pin_oe_o, 32'h0000_0F00);
    wr(8'h54, 32'hA5);
    check("R3 pin_o bank1", pin_o, 32'h0000_A500);
    rd(8'h50, 32'hF0, "R3 dir readback");
    rd(8'h14, 32'h00, "R2 bank0 out untouched");

    // R4 / R5 / R2 pin 10 rising edge
    @(negedge clk); pin_i = 32'h0000_0400;
    settle(2);
    rd(8'h58, 32'h04, "R4 input pin10");
    rd(8'h44, 32'h04, "R5 edge pend");
    rd(8'h40, 32'h00, "R9 masked");
    check("R10 irq masked", {31'h0, irq_o}, 32'h0);

    // R8 unmask
    wr(8'h4C, 32'h04);
    rd(8'h48, 32'hFB, "R8 mask after clear");
    check("R10 irq unmasked", {31'h0, irq_o}, 32'h1);
    wr(8'h40, 32'hFF);
    rd(8'h40, 32'h04, "R9 masked write ignored");

    // R7 clear
    wr(8'h44, 32'h00);
    rd(8'h44, 32'h04, "R7 zero write keeps");
    wr(8'h44, 32'h04);
    rd(8'h44, 32'h00, "R7 clear");
    check("R10 irq after clear", {31'h0, irq_o}, 32'h0);
    settle(4);
    rd(8'h44, 32'h00, "R5 held high no retrigger");

    // R11 / R6 level pin 8
    wr(8'h60, 32'h01);
    rd(8'h60, 32'h01, "R11 type readback");
    @(negedge clk); pin_i = 32'h0000_0500;
    settle(3);
    rd(8'h44, 32'h01, "R6 level pend");
    wr(8'h44, 32'h01);
    rd(8'h44, 32'h01, "R6 clear while high");
    @(negedge clk); pin_i = 32'h0000_0400;
    settle(3);
    wr(8'h44, 32'h01);
    rd(8'h44, 32'h00, "R6 clear after low");

    // R10 multi-bank then mask all
    wr(8'hCC, 32'hFF);
    wr(8'h0C, 32'h01);
    @(negedge clk); pin_i = 32'hFF00_0401;
    settle(3);
    rd(8'hC0, 32'hFF, "R9 bank3 masked");
    check("R10 irq multi", {31'h0, irq_o}, 32'h1);
    wr(8'h08, 32'hFF);
    wr(8'h48, 32'hFF);
    wr(8'h88, 32'hFF);
    check("R10 irq partial mask", {31'h0, irq_o}, 32'h1);
    wr(8'hC8, 32'hFF);
    check("R10 irq all masked", {31'h0, irq_o}, 32'h0);
    rd(8'hC4, 32'hFF, "R7 raw kept under mask");
    rd(8'h18, 32'h01, "R4 bank0 input");

    settle(3);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R12: missing acks actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule